// File: doc/BRIEF.md
# Interleaved Multichannel Second-Order IIR Section

This block runs one second-order recursive filter section for many independent channels with a single set of five multipliers. Samples for the channels arrive time-interleaved, one per clock, in strict rotating order from channel 0 up to channel NCH-1 and back to 0. Every unit delay of the usual single-channel section becomes a chain of NCH registers. When a sample for channel c enters, the register chains present exactly that channel's own earlier inputs and outputs. All channels therefore share one datapath but keep fully separate state.

The structure is direct form I: y = b0·x + b1·x[n-1] + b2·x[n-2] − a1·y[n-1] − a2·y[n-2]. Samples are 18-bit two's complement. The five coefficients are 18-bit signed values in Q2.16 (16 fraction bits) and are common to all channels. Products are summed in a 40-bit accumulator. The result is then rounded and saturated back to 18 bits. That 18-bit result is both the output and the value fed back. A clock with the input valid low is a gap: it freezes every register chain, so channel alignment survives the pause. The output carries the channel number of the sample it belongs to, one clock after that sample was accepted.

Top module: `mc_biquad`

## Requirements
- R1: While reset is active and in the first clock after it, out_vld is 0 and out_smp is 0. Reset clears every delay register of every channel to zero, so the first output of each channel after reset equals round(b0·x).
- R2: An input accepted with in_vld=1 produces out_vld=1 exactly one clock later. out_ch equals the accepted in_ch.
- R3: Each output equals sat(floor((b0·x + b1·x1 + b2·x2 − a1·y1 − a2·y2 + 2^15) / 2^16)). Here x1 and x2 are the channel's previous two accepted inputs, and y1 and y2 are its previous two outputs. The division uses arithmetic right shift by 16, so halves round upward.
- R4: A sample on one channel has no effect on any other channel's outputs.
- R5: Results above 131071 give 131071, and results below −131072 give −131072. The saturated value is also the value fed back.
- R6: A clock with in_vld=0 changes no channel state. The next clock shows out_vld=0 with out_smp and out_ch unchanged. A stream with gaps yields the same outputs as the same stream without gaps.
- R7: Accepted samples must carry channel numbers 0,1,…,NCH-1,0,… in order, starting at 0 after reset.
- R8: The same behaviour holds for NCH=4 and NCH=20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input sample valid |
| in_ch | input | CHW | Channel of the input sample |
| in_smp | input | DW | Input sample, signed |
| coef_b0 | input | CW | Feedforward coefficient 0, Q2.16 |
| coef_b1 | input | CW | Feedforward coefficient 1, Q2.16 |
| coef_b2 | input | CW | Feedforward coefficient 2, Q2.16 |
| coef_a1 | input | CW | Feedback coefficient 1, Q2.16 (subtracted) |
| coef_a2 | input | CW | Feedback coefficient 2, Q2.16 (subtracted) |
| out_vld | output | 1 | Output sample valid |
| out_ch | output | CHW | Channel of the output sample |
| out_smp | output | DW | Filtered sample, signed |

## Verification
An impulse on a single channel, with nonzero feedback, shows that the response rings only in that channel's own slot and that the other slots stay exactly zero. This separates correct per-channel chains from chains that are off by one stage. Long random streams, with and without random gaps, compare every output against an arithmetic model. They tell a correct stall apart from a chain that drifts during idle clocks. Small odd inputs at gain 0.5 expose the rounding direction. Full-scale inputs at high gain drive both saturation rails and confirm that the clipped value is the one fed back. The random stream is repeated with 20 channels to confirm that the chain length follows the parameter.

// File: rtl/mcbq_pkg.sv
package mcbq_pkg;
    localparam int DATA_W = 18;
    localparam int COEF_W = 18;
    localparam int FRAC_W = 16;
    localparam int ACC_W  = 40;

    function automatic int ch_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/mcbq_dline.sv
// Register chain of 2*NCH stages; taps give the same channel's value
// one and two rotations ago.
module mcbq_dline #(
    parameter int W   = 18,
    parameter int NCH = 4,
    localparam int LEN = 2 * NCH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] tap1,
    output logic [W-1:0] tap2
);
    for (genvar i = 0; i < LEN; i++) begin : g_stg
        logic [W-1:0] r_d, r_q;
        if (i == 0) begin : g_head
            always_comb r_d = en ? din : r_q;
        end else begin : g_body
            always_comb r_d = en ? g_stg[i-1].r_q : r_q;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= '0;
            else        r_q <= r_d;
        end
    end

    assign tap1 = g_stg[NCH-1].r_q;
    assign tap2 = g_stg[LEN-1].r_q;
endmodule

// File: rtl/mcbq_mac.sv
// Five products, wide sum, round half up, saturate.
module mcbq_mac #(
    parameter int DW = 18,
    parameter int CW = 18,
    parameter int FW = 16,
    parameter int AW = 40
) (
    input  logic signed [DW-1:0] x0,
    input  logic signed [DW-1:0] x1,
    input  logic signed [DW-1:0] x2,
    input  logic signed [DW-1:0] y1,
    input  logic signed [DW-1:0] y2,
    input  logic signed [CW-1:0] b0,
    input  logic signed [CW-1:0] b1,
    input  logic signed [CW-1:0] b2,
    input  logic signed [CW-1:0] a1,
    input  logic signed [CW-1:0] a2,
    output logic signed [DW-1:0] y
);
    localparam int PW = DW + CW;
    localparam int NT = 5;
    localparam logic signed [AW-1:0] HALF = {{(AW-1){1'b0}}, 1'b1} << (FW - 1);
    localparam logic signed [AW-1:0] MAXV = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [AW-1:0] MINV = ~MAXV;

    logic signed [DW-1:0] opx [NT];
    logic signed [CW-1:0] opc [NT];
    logic signed [PW-1:0] prd [NT];
    logic signed [AW-1:0] ext [NT];
    logic signed [AW-1:0] acc, rnd, sh;

    assign opx[0] = x0; assign opc[0] = b0;
    assign opx[1] = x1; assign opc[1] = b1;
    assign opx[2] = x2; assign opc[2] = b2;
    assign opx[3] = y1; assign opc[3] = a1;
    assign opx[4] = y2; assign opc[4] = a2;

    for (genvar k = 0; k < NT; k++) begin : g_prd
        assign prd[k] = opx[k] * opc[k];
        assign ext[k] = {{(AW-PW){prd[k][PW-1]}}, prd[k]};
    end

    always_comb begin
        acc = ext[0] + ext[1] + ext[2] - ext[3] - ext[4];
        rnd = acc + HALF;
        sh  = rnd >>> FW;
        if (sh > MAXV)      y = MAXV[DW-1:0];
        else if (sh < MINV) y = MINV[DW-1:0];
        else                y = sh[DW-1:0];
    end
endmodule

// File: rtl/mc_biquad.sv
module mc_biquad
    import mcbq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = DATA_W,
    parameter int CW  = COEF_W,
    parameter int FW  = FRAC_W,
    parameter int AW  = ACC_W,
    localparam int CHW = ch_width(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_vld,
    input  logic [CHW-1:0] in_ch,
    input  logic [DW-1:0]  in_smp,
    input  logic [CW-1:0]  coef_b0,
    input  logic [CW-1:0]  coef_b1,
    input  logic [CW-1:0]  coef_b2,
    input  logic [CW-1:0]  coef_a1,
    input  logic [CW-1:0]  coef_a2,
    output logic           out_vld,
    output logic [CHW-1:0] out_ch,
    output logic [DW-1:0]  out_smp
);
    typedef struct packed {
        logic           vld;
        logic [CHW-1:0] ch;
        logic [DW-1:0]  smp;
    } ostate_t;

    ostate_t st_d, st_q;
    logic [DW-1:0] xt1, xt2, yt1, yt2;
    logic signed [DW-1:0] y_new;

    mcbq_dline #(.W(DW), .NCH(NCH)) u_xline (
        .clk(clk), .rst_n(rst_n), .en(in_vld), .din(in_smp),
        .tap1(xt1), .tap2(xt2)
    );

    mcbq_dline #(.W(DW), .NCH(NCH)) u_yline (
        .clk(clk), .rst_n(rst_n), .en(in_vld), .din(y_new),
        .tap1(yt1), .tap2(yt2)
    );

    mcbq_mac #(.DW(DW), .CW(CW), .FW(FW), .AW(AW)) u_mac (
        .x0(in_smp), .x1(xt1), .x2(xt2), .y1(yt1), .y2(yt2),
        .b0(coef_b0), .b1(coef_b1), .b2(coef_b2),
        .a1(coef_a1), .a2(coef_a2),
        .y(y_new)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.ch  = in_ch;
            st_d.smp = y_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld = st_q.vld;
    assign out_ch  = st_q.ch;
    assign out_smp = st_q.smp;
endmodule

// File: rtl/mcbq_chk.sv
module mcbq_chk
    import mcbq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = DATA_W,
    localparam int CHW = ch_width(NCH)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_vld,
    input logic [CHW-1:0] in_ch,
    input logic           out_vld,
    input logic [CHW-1:0] out_ch,
    input logic [DW-1:0]  out_smp
);
    logic [CHW-1:0] nxt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      nxt_q <= '0;
        else if (in_vld) nxt_q <= (in_ch == CHW'(NCH - 1)) ? '0 : in_ch + CHW'(1);
    end

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_idle_chk: assert (!out_vld && out_smp == '0);
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    // R2
    chan_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_ch == $past(in_ch));

    // R6
    gap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

    // R6
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(out_smp) && $stable(out_ch)));

    // R7
    rr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |-> in_ch == nxt_q);
endmodule

bind mc_biquad mcbq_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_ch(in_ch),
    .out_vld(out_vld), .out_ch(out_ch), .out_smp(out_smp)
);

// File: tb/sim_mc_biquad.sv
module sim_mc_biquad;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int b0 = 0, b1 = 0, b2 = 0, a1 = 0, a2 = 0;

    logic        v0 = 1'b0, v1 = 1'b0;
    logic [1:0]  c0 = '0;
    logic [4:0]  c1 = '0;
    logic [17:0] s0 = '0, s1 = '0;
    logic        o0_vld, o1_vld;
    logic [1:0]  o0_ch;
    logic [4:0]  o1_ch;
    logic [17:0] o0_smp, o1_smp;

    mc_biquad #(.NCH(4)) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(v0), .in_ch(c0), .in_smp(s0),
        .coef_b0(b0[17:0]), .coef_b1(b1[17:0]), .coef_b2(b2[17:0]),
        .coef_a1(a1[17:0]), .coef_a2(a2[17:0]),
        .out_vld(o0_vld), .out_ch(o0_ch), .out_smp(o0_smp)
    );

    mc_biquad #(.NCH(20)) u1 (
        .clk(clk), .rst_n(rst_n), .in_vld(v1), .in_ch(c1), .in_smp(s1),
        .coef_b0(b0[17:0]), .coef_b1(b1[17:0]), .coef_b2(b2[17:0]),
        .coef_a1(a1[17:0]), .coef_a2(a2[17:0]),
        .out_vld(o1_vld), .out_ch(o1_ch), .out_smp(o1_smp)
    );

    // arithmetic model, index 0 for 4 channels, 1 for 20 channels
    longint mx1 [2][20], mx2 [2][20], my1 [2][20], my2 [2][20];
    int nxt_ch [2];
    int last_y [2];
    int last_ch [2];

    function automatic longint model_y(input int k, input int ch, input longint x);
        longint acc, r;
        acc = b0 * x + b1 * mx1[k][ch] + b2 * mx2[k][ch]
            - a1 * my1[k][ch] - a2 * my2[k][ch];
        r = (acc + 64'sd32768) >>> 16;
        if (r > 131071)  r = 131071;
        if (r < -131072) r = -131072;
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint got, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            for (int c = 0; c < 20; c++) begin
                mx1[k][c] = 0; mx2[k][c] = 0; my1[k][c] = 0; my2[k][c] = 0;
            end
            nxt_ch[k] = 0; last_y[k] = 0; last_ch[k] = 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; v0 = 1'b0; v1 = 1'b0;
        repeat (3) @(negedge clk);
        check(o0_vld == 1'b0 && o0_smp == '0, "R1", "outputs in reset", o0_smp, 0);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        check(o0_vld == 1'b0 && o1_vld == 1'b0 && o0_smp == '0 && o1_smp == '0,
              "R1", "outputs after reset", o0_smp, 0);
    endtask

    // called at a negedge; returns at the next negedge after checking
    task automatic step(input int k, input bit v, input longint x, input string tag);
        int n, ch, gotv, gotc, goty;
        longint y;
        n = (k == 0) ? 4 : 20;
        ch = nxt_ch[k];
        y = 0;
        if (k == 0) begin v0 = v; c0 = ch[1:0]; s0 = x[17:0]; end
        else        begin v1 = v; c1 = ch[4:0]; s1 = x[17:0]; end
        if (v) y = model_y(k, ch, x);
        @(posedge clk);
        @(negedge clk);
        gotv = (k == 0) ? int'(o0_vld) : int'(o1_vld);
        gotc = (k == 0) ? int'(o0_ch) : int'(o1_ch);
        goty = (k == 0) ? int'($signed(o0_smp)) : int'($signed(o1_smp));
        if (v) begin
            check(gotv == 1 && gotc == ch, "R2", "valid/channel", gotc, ch);
            check(goty == y, tag, "sample", goty, y);
            mx2[k][ch] = mx1[k][ch]; mx1[k][ch] = x;
            my2[k][ch] = my1[k][ch]; my1[k][ch] = y;
            last_y[k] = int'(y); last_ch[k] = ch;
            nxt_ch[k] = (ch == n - 1) ? 0 : ch + 1;
        end else begin
            check(gotv == 0 && goty == last_y[k] && gotc == last_ch[k],
                  "R6", "gap holds output", goty, last_y[k]);
        end
        if (k == 0) v0 = 1'b0; else v1 = 1'b0;
    endtask

    function automatic longint rnd18();
        logic [17:0] r;
        r = 18'($urandom());
        return longint'($signed(r));
    endfunction

    initial begin
        #(1_000_000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int sat_hi, sat_lo;
        model_reset();
        // R1: first outputs after reset depend only on b0*x
        b0 = 32768; b1 = 40000; b2 = -20000; a1 = -70000; a2 = 30000;
        do_reset();
        for (int i = 0; i < 4; i++) step(0, 1'b1, 1000 * (i + 1), "R1");
        check(my1[0][3] == 2000, "R1", "first output b0 only", my1[0][3], 2000);

        // R3: rounding at gain 0.5, halves go up
        b0 = 32768; b1 = 0; b2 = 0; a1 = 0; a2 = 0;
        do_reset();
        step(0, 1'b1, 1, "R3");
        check(last_y[0] == 1, "R3", "0.5 rounds to 1", last_y[0], 1);
        step(0, 1'b1, -1, "R3");
        check(last_y[0] == 0, "R3", "-0.5 rounds to 0", last_y[0], 0);
        step(0, 1'b1, 3, "R3");
        step(0, 1'b1, -3, "R3");
        check(last_y[0] == -1, "R3", "-1.5 rounds to -1", last_y[0], -1);

        // R4: impulse on channel 2 only, resonant feedback
        b0 = 65536; b1 = 32768; b2 = 16384; a1 = -98304; a2 = 52429;
        do_reset();
        for (int i = 0; i < 160; i++) begin
            longint x;
            x = (i == 2) ? 60000 : 0;
            step(0, 1'b1, x, "R4");
            if (nxt_ch[0] != 3)
                check(last_y[0] == 0 || last_ch[0] == 2, "R4", "other channel silent",
                      last_y[0], 0);
        end

        // R3: random stream, per-channel recursion
        b0 = 20000; b1 = 40000; b2 = 20000; a1 = -80000; a2 = 40000;
        do_reset();
        for (int i = 0; i < 1500; i++) step(0, 1'b1, rnd18(), "R3");

        // R6: random gaps
        for (int i = 0; i < 1500; i++)
            step(0, ($urandom() % 10) < 7, rnd18(), "R6");

        // R5: saturation on both rails, feedback uses clipped value
        b0 = 130000; b1 = 130000; b2 = 130000; a1 = -65536; a2 = 0;
        do_reset();
        sat_hi = 0; sat_lo = 0;
        for (int i = 0; i < 200; i++) begin
            longint x;
            x = ((i / 40) % 2 == 0) ? 131071 : -131072;
            step(0, 1'b1, x, "R5");
            if (last_y[0] == 131071)  sat_hi++;
            if (last_y[0] == -131072) sat_lo++;
        end
        check(sat_hi > 0, "R5", "upper rail reached", sat_hi, 1);
        check(sat_lo > 0, "R5", "lower rail reached", sat_lo, 1);

        // R8: twenty channels, random stream with gaps
        b0 = 20000; b1 = 40000; b2 = 20000; a1 = -80000; a2 = 40000;
        do_reset();
        for (int i = 0; i < 2000; i++)
            step(1, ($urandom() % 10) < 8, rnd18(), "R8");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule